// File: doc/BRIEF.md
# SD Card Clock Control Unit

This block turns a base clock into the clock that drives an SD card. Software controls it through one 16-bit control word. The word holds an 8-bit frequency select, an internal clock enable, a read-only flag that reports a settled internal clock, and a card clock enable. The card clock runs at the base clock divided by twice the select value. A select of zero passes the base clock straight through.

Bringing up the clock takes a fixed sequence. Software first writes the word with zeros to stop everything. It then writes the new select together with the internal enable and waits for the settled flag. Only after the flag is set does it add the card clock enable. To reach the 400 kHz identification rate from a base clock of about 24.7 MHz, software uses a select of 31, which gives a total division of 62. Clearing only the card clock enable, for example while pad calibration runs, parks the card clock low and leaves the internal clock settled. Setting the enable again resumes the clock without a new wait.

Top module: `sdclk_ctrl`

## Requirements
- R1: The read word contains the frequency select in bits [15:8], the card clock enable in bit 2, the settled flag in bit 1 and the internal enable in bit 0. Bits [7:3] read as zero. A write sets bits [15:8], 2 and 0, and a write to bit 1 has no effect.
- R2: After reset the read word is 0x0000 and the card clock is low.
- R3: When a write sets the internal enable while it was clear, the settled flag reads 1 exactly SETTLE base-clock cycles later and not before.
- R4: A write with bit 0 clear clears the settled flag in the same cycle. A write of all zeros stops the card clock, which then stays low.
- R5: The card clock stays low unless the card clock enable and the settled flag are both set.
- R6: With select value N greater than 0, the card clock is high for N base cycles and low for N base cycles, so the division ratio is 2N.
- R7: With select value 0, the card clock equals the base clock while it is enabled.
- R8: A select of 31 gives a card clock period of 62 base cycles.
- R9: A new select written while the internal enable stays set shows on read-back but leaves the card clock unchanged. It takes effect only after the internal enable is cleared and set again.
- R10: Clearing and then setting only the card clock enable stops and restarts the card clock. The settled flag stays set throughout, so no new wait is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word, including the settled flag |
| card_clk | output | 1 | Gated and divided card clock |

## Verification
The assertions check the following on every cycle:
- the settled flag is never set without the internal enable;
- a write that clears bit 0 drops both the enable and the flag;
- written fields appear on read-back;
- the card clock is parked low whenever the card enable or the settled flag was clear.

Some behaviour only the bench scenarios can show:
- the exact settle delay;
- the high and low lengths for each select value;
- the undivided mode;
- that a mid-run select change is held back until the enable handshake is repeated.

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl #(
  parameter int SEL_W  = 8,
  parameter int SETTLE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W+7:0]   wr_data,
  output logic [SEL_W+7:0]   rd_data,
  output logic               card_clk
);
  localparam int REG_W = SEL_W + 8;
  localparam int CW    = $clog2(SETTLE + 1);
  localparam logic [SEL_W-1:0] ONE = 1;
  localparam logic [CW-1:0]    LAST = CW'(SETTLE - 1);

  logic [SEL_W-1:0] sel_q, act_sel, div_cnt;
  logic [CW-1:0]    settle_q;
  logic             int_en_q, card_en_q, stable_q, div_q, run_lo;
  logic             run, bypass;

  assign run     = card_en_q & stable_q;
  assign bypass  = (act_sel == '0);
  assign rd_data = {sel_q, 5'b0, card_en_q, stable_q, int_en_q};
  assign card_clk = bypass ? (clk & run_lo) : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      act_sel   <= '0;
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
    end else if (wr_en) begin
      sel_q     <= wr_data[REG_W-1:8];
      int_en_q  <= wr_data[0];
      card_en_q <= wr_data[2];
      if (wr_data[0] && !int_en_q) act_sel <= wr_data[REG_W-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      settle_q <= '0;
    end else if (wr_en && !wr_data[0]) begin
      stable_q <= 1'b0;
      settle_q <= '0;
    end else if (int_en_q && !stable_q) begin
      if (settle_q == LAST) stable_q <= 1'b1;
      else                  settle_q <= settle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      div_q   <= 1'b0;
    end else if (!run || bypass) begin
      div_cnt <= '0;
      div_q   <= 1'b0;
    end else if (div_cnt == act_sel - ONE) begin
      div_cnt <= '0;
      div_q   <= ~div_q;
    end else begin
      div_cnt <= div_cnt + ONE;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_lo <= 1'b0;
    else        run_lo <= run & bypass;
  end
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W+7:0] wr_data,
  input logic [SEL_W+7:0] rd_data,
  input logic             card_clk
);
  localparam int REG_W = SEL_W + 8;

  // R3: settled flag only with internal enable
  a_r3_stable_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]);

  // R3: flag rises only after enable was already set
  a_r3_rise_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $past(rd_data[0]));

  // R4: clearing bit 0 drops enable and flag
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> (!rd_data[0] && !rd_data[1]));

  // R1: written fields read back, reserved bits zero
  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[REG_W-1:8] == $past(wr_data[REG_W-1:8]) &&
               rd_data[2] == $past(wr_data[2]) && rd_data[7:3] == 5'b0));

  // R5: card clock parked when gated
  a_r5_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[2] && rd_data[1]) |=> !card_clk);
endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_sdclk_ctrl.sv
module sim_sdclk_ctrl;
  localparam int SETTLE = 8;
  localparam int NV = 5;
  localparam int TBL_SEL  [NV] = '{1, 2, 3, 5, 31};
  localparam int TBL_HALF [NV] = '{1, 2, 3, 5, 31};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic card_clk;
  int n_run = 0, n_fail = 0, wd = 0;
  int hi, lo;

  always #2 clk = ~clk;

  sdclk_ctrl #(.SEL_W(8), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .card_clk(card_clk));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int h, output int l);
    h = 0; l = 0;
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    while (card_clk === 1'b1) begin h++; @(negedge clk); end
    while (card_clk === 1'b0) begin l++; @(negedge clk); end
  endtask

  task automatic start(input int sel);
    wr(16'h0000);
    wr({8'(sel), 8'h01});
    cyc(SETTLE);
    wr({8'(sel), 8'h05});
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R2 reset word", rd_data, 0);
    chk("R2 reset clk", card_clk, 0);
    rst_n = 1'b1;
    cyc(2);

    wr(16'h0002);
    chk("R1 bit1 read-only", rd_data, 0);
    wr(16'hAB05);
    chk("R1 layout", rd_data, 16'hAB05);
    wr(16'h0000);
    chk("R4 zero clears", rd_data, 0);

    wr(16'h0001);
    cyc(SETTLE - 1);
    chk("R3 not yet settled", rd_data[1], 0);
    cyc(1);
    chk("R3 settled", rd_data[1], 1);
    cyc(5);
    chk("R5 gated low without card enable", card_clk, 0);

    for (int v = 0; v < NV; v++) begin
      start(TBL_SEL[v]);
      measure(hi, lo);
      chk($sformatf("R6 high sel=%0d", TBL_SEL[v]), hi, TBL_HALF[v]);
      chk($sformatf("R6 low sel=%0d", TBL_SEL[v]), lo, TBL_HALF[v]);
    end
    chk("R8 ident period 62", hi + lo, 62);

    start(4);
    wr(16'h0905);
    chk("R9 readback new sel", rd_data[15:8], 9);
    measure(hi, lo);
    chk("R9 old divisor kept", hi, 4);
    start(9);
    measure(hi, lo);
    chk("R9 new divisor after handshake", hi, 9);

    start(3);
    wr(16'h0301);
    cyc(2);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= card_clk; end
      chk("R10 parked while card enable clear", seen, 0);
    end
    chk("R10 flag kept", rd_data[1], 1);
    wr(16'h0305);
    measure(hi, lo);
    chk("R10 resumes", hi, 3);

    wr(16'h0000);
    chk("R4 flag cleared", rd_data[1], 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= card_clk; end
      chk("R4 clock stopped", seen, 0);
    end

    start(0);
    cyc(3);
    chk("R7 low phase", card_clk, 0);
    @(posedge clk); #1;
    chk("R7 high phase", card_clk, 1);
    @(negedge clk);
    chk("R7 follows base", card_clk, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule